// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides which interrupt a small 8-bit processor core takes next. Fourteen peripheral request flags come in, each with its own enable bit. The enabled flags are folded into eight numbered status groups, and several peripherals may share one group. The block also receives the global interrupt mask bit from the condition code register and a software-interrupt strobe from the instruction decoder.

On an instruction-boundary strobe the controller picks the pending request with the lowest level number. It then latches a 16-bit vector address together with the return address that the stacking logic must push. The grant stays frozen until the core acknowledges it.

The status groups can be read as a live view of what is pending. Each flag is cleared at its own peripheral, never here.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `irq_status` bit k-1 is 1 exactly when at least one source of group k has both its flag and its enable at 1. A source whose enable is 0 never shows in the status.
- R2: Source index to group mapping:
  - index 0 goes to group 1;
  - indices 1 to 4 go to group 2;
  - indices 5 and 6 go to group 3;
  - indices 7 to 9 go to group 4;
  - index 10 goes to group 5, 11 to group 6, 12 to group 7 and 13 to group 8.
- R3: When several groups are pending, only the group with the lowest number is granted.
- R4: A software interrupt is granted whatever the value of `i_mask`. It wins over every hardware group and uses vector 0xFFFC.
- R5: While `i_mask` is 1, no hardware group is granted.
- R6: A hardware grant for group g carries vector 0xFFFA minus 2*(g-1). Group 1 therefore uses 0xFFFA and group 8 uses 0xFFEC.
- R7: The latched return address equals `pc` for a software interrupt and `pc`-1 for a hardware interrupt. `pc` is sampled on the granting edge.
- R8: A grant starts only on a clock edge where `boundary` is 1. `take` rises in the following cycle.
- R9: While `take` is 1 and `ack` is 0, `vec_addr` and `ret_addr` hold their values, and new requests or strobes are ignored. An edge with `ack` at 1 clears `take`.
- R10: `irq_status` depends only on the flags and enables. It does not change with `i_mask`, `swi_req` or the grant state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flag | input | 14 | Peripheral request flags |
| src_en | input | 14 | Per-source enable bits |
| i_mask | input | 1 | Global interrupt mask (1 = hardware blocked) |
| swi_req | input | 1 | Software interrupt strobe from the decoder |
| boundary | input | 1 | Instruction-boundary strobe |
| pc | input | 16 | Current program counter |
| ack | input | 1 | Core acknowledges the held grant |
| irq_status | output | 8 | Pending group flags, bit 0 = group 1 |
| take | output | 1 | A grant is held |
| vec_addr | output | 16 | Vector address of the held grant |
| ret_addr | output | 16 | Return address to stack |

## Verification
Each source is raised alone, first enabled and then disabled, to separate a wrong group mapping from a missing enable gate in the status. Each group is granted alone to confirm its vector and the pc-1 return address.

Pairs of pending groups, and a software strobe added on top of all groups with the mask set, show whether the priority order and the mask bypass are correct. A strobe sent with the mask set, and a request left pending without any strobe, show whether the gating works. Changing requests and pc while a grant is held shows whether the latch holds its values until the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 14;
  localparam int NGRP  = 8;
  localparam int LVL_W = $clog2(NGRP + 1);
  localparam logic [15:0] VEC_TOP = 16'hFFFC;

  // group number (1..NGRP) of each source index
  function automatic int src_group(input int idx);
    if (idx == 0)       return 1;
    else if (idx <= 4)  return 2;
    else if (idx <= 6)  return 3;
    else if (idx <= 9)  return 4;
    else                return idx - 5;
  endfunction

  // vector for a priority level: level 0 is the software interrupt
  function automatic logic [15:0] level_vector(input logic [LVL_W-1:0] lvl);
    return VEC_TOP - {11'd0, lvl, 1'b0};
  endfunction
endpackage

// File: rtl/irq_group_map.sv
module irq_group_map
  import irq_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int N_GRP = NGRP
) (
  input  logic [N_SRC-1:0] src_flag,
  input  logic [N_SRC-1:0] src_en,
  output logic [N_GRP-1:0] grp_status
);
  logic [N_SRC-1:0] src_live;
  assign src_live = src_flag & src_en;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_comb begin
      grp_status[g] = 1'b0;
      for (int i = 0; i < N_SRC; i++)
        if (src_group(i) == g + 1) grp_status[g] = grp_status[g] | src_live[i];
    end
  end

  // R1
  always_comb begin
    status_quiet_chk: assert (!(src_live == '0 && grp_status != '0));
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
#(
  parameter int N_GRP = NGRP,
  parameter int LW    = LVL_W
) (
  input  logic [N_GRP-1:0] grp_status,
  input  logic             i_mask,
  input  logic             swi_req,
  output logic             req_valid,
  output logic             req_is_swi,
  output logic [LW-1:0]    req_level
);
  logic          hw_valid;
  logic [LW-1:0] hw_level;

  always_comb begin
    hw_valid = 1'b0;
    hw_level = '0;
    for (int g = N_GRP - 1; g >= 0; g--)
      if (grp_status[g]) begin
        hw_valid = 1'b1;
        hw_level = LW'(g + 1);
      end
  end

  assign req_is_swi = swi_req;
  assign req_valid  = swi_req | (hw_valid & ~i_mask);
  assign req_level  = swi_req ? '0 : hw_level;

  // R4
  always_comb begin
    swi_top_chk: assert (!(swi_req && req_level != '0));
  end
  // R3
  always_comb begin
    lowest_grp_chk: assert (!(hw_valid && hw_level != '0 && !grp_status[hw_level - 1'b1]));
  end
endmodule

// File: rtl/irq_grant_reg.sv
module irq_grant_reg
  import irq_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          req_valid,
  input  logic          req_is_swi,
  input  logic [LW-1:0] req_level,
  input  logic [15:0]   pc,
  input  logic          ack,
  output logic          take,
  output logic [15:0]   vec_addr,
  output logic [15:0]   ret_addr
);
  logic grant_fire;
  assign grant_fire = boundary & ~take & req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take     <= 1'b0;
      vec_addr <= 16'h0000;
      ret_addr <= 16'h0000;
    end else if (grant_fire) begin
      take     <= 1'b1;
      vec_addr <= level_vector(req_level);
      ret_addr <= req_is_swi ? pc : pc - 16'd1;
    end else if (take && ack) begin
      take <= 1'b0;
    end
  end

  // R9
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !ack |=> take && $stable(vec_addr) && $stable(ret_addr));
  // R8
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> $past(boundary));
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && ack |=> !take);
  // R7
  swi_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take && boundary && req_is_swi |=> ret_addr == $past(pc));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int N_GRP = NGRP,
  localparam int LW   = $clog2(N_GRP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_flag,
  input  logic [N_SRC-1:0] src_en,
  input  logic             i_mask,
  input  logic             swi_req,
  input  logic             boundary,
  input  logic [15:0]      pc,
  input  logic             ack,
  output logic [N_GRP-1:0] irq_status,
  output logic             take,
  output logic [15:0]      vec_addr,
  output logic [15:0]      ret_addr
);
  logic          req_valid;
  logic          req_is_swi;
  logic [LW-1:0] req_level;

  irq_group_map #(.N_SRC(N_SRC), .N_GRP(N_GRP)) u_map (
    .src_flag(src_flag), .src_en(src_en), .grp_status(irq_status));

  irq_prio_sel #(.N_GRP(N_GRP), .LW(LW)) u_sel (
    .grp_status(irq_status), .i_mask(i_mask), .swi_req(swi_req),
    .req_valid(req_valid), .req_is_swi(req_is_swi), .req_level(req_level));

  irq_grant_reg #(.LW(LW)) u_grant (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .req_valid(req_valid),
    .req_is_swi(req_is_swi), .req_level(req_level), .pc(pc), .ack(ack),
    .take(take), .vec_addr(vec_addr), .ret_addr(ret_addr));

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take && boundary && i_mask && !swi_req |=> !take);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src_flag = '0;
  logic [13:0] src_en = '0;
  logic        i_mask = 1'b0;
  logic        swi_req = 1'b0;
  logic        boundary = 1'b0;
  logic [15:0] pc = 16'h0000;
  logic        ack = 1'b0;
  logic [7:0]  irq_status;
  logic        take;
  logic [15:0] vec_addr;
  logic [15:0] ret_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (.*);

  function automatic int grp_of(input int s);
    case (s)
      0: return 1;
      1, 2, 3, 4: return 2;
      5, 6: return 3;
      7, 8, 9: return 4;
      10: return 5;
      11: return 6;
      12: return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic [15:0] hw_vec(input int g);
    return 16'hFFEC + 16'(2 * (8 - g));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    src_flag = '0; src_en = '0; i_mask = 1'b0; swi_req = 1'b0;
    boundary = 1'b0; ack = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0; swi_req = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R9 ack clears take", {31'd0, take}, 32'd0);
  endtask

  task automatic t_reset();
    chk("reset take", {31'd0, take}, 32'd0);
    chk("reset vec", {16'd0, vec_addr}, 32'd0);
    chk("R1 reset status", {24'd0, irq_status}, 32'd0);
  endtask

  task automatic t_status_map();
    for (int s = 0; s < 14; s++) begin
      @(negedge clk);
      src_flag = 14'(1 << s); src_en = 14'(1 << s); i_mask = 1'b1;
      #1 chk($sformatf("R2 src %0d group", s), {24'd0, irq_status}, 32'(1 << (grp_of(s) - 1)));
      src_en = ~src_en;
      #1 chk($sformatf("R1 src %0d disabled", s), {24'd0, irq_status}, 32'd0);
    end
    src_flag = 14'h3FFF; src_en = 14'h3FFF; i_mask = 1'b0; swi_req = 1'b1;
    #1 chk("R10 status unaffected by mask/swi", {24'd0, irq_status}, 32'hFF);
    clear_inputs();
  endtask

  task automatic t_each_group();
    for (int g = 1; g <= 8; g++) begin
      int s;
      s = (g == 1) ? 0 : (g == 2) ? 3 : (g == 3) ? 6 : (g == 4) ? 9 : g + 5;
      @(negedge clk);
      src_flag = 14'(1 << s); src_en = 14'(1 << s); pc = 16'(16'h1200 + g);
      strobe();
      chk($sformatf("R8 take grp %0d", g), {31'd0, take}, 32'd1);
      chk($sformatf("R6 vec grp %0d", g), {16'd0, vec_addr}, {16'd0, hw_vec(g)});
      chk($sformatf("R7 hw ret grp %0d", g), {16'd0, ret_addr}, 32'(16'h1200 + g - 1));
      do_ack();
      clear_inputs();
    end
  endtask

  task automatic t_priority();
    @(negedge clk);
    src_flag = 14'b10_0000_0100_0000; src_en = 14'h3FFF;
    strobe();
    chk("R3 grp3 over grp8", {16'd0, vec_addr}, 32'hFFF6);
    do_ack();
    @(negedge clk);
    src_flag = 14'b00_0100_0000_0010;
    strobe();
    chk("R3 grp2 over grp5", {16'd0, vec_addr}, 32'hFFF8);
    do_ack();
    clear_inputs();
  endtask

  task automatic t_swi();
    @(negedge clk);
    src_flag = 14'h3FFF; src_en = 14'h3FFF; i_mask = 1'b1; swi_req = 1'b1; pc = 16'h4321;
    strobe();
    chk("R4 swi taken under mask", {31'd0, take}, 32'd1);
    chk("R4 swi vector", {16'd0, vec_addr}, 32'hFFFC);
    chk("R7 swi ret = pc", {16'd0, ret_addr}, 32'h4321);
    do_ack();
    clear_inputs();
  endtask

  task automatic t_mask();
    @(negedge clk);
    src_flag = 14'h3FFF; src_en = 14'h3FFF; i_mask = 1'b1;
    strobe();
    chk("R5 masked no take", {31'd0, take}, 32'd0);
    i_mask = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 no strobe no take", {31'd0, take}, 32'd0);
    clear_inputs();
  endtask

  task automatic t_hold();
    @(negedge clk);
    src_flag = 14'h2000; src_en = 14'h3FFF; pc = 16'h0800;
    strobe();
    chk("R6 grp8 vec", {16'd0, vec_addr}, 32'hFFEC);
    src_flag = 14'h0001; pc = 16'h9999; swi_req = 1'b1;
    strobe();
    chk("R9 vec held", {16'd0, vec_addr}, 32'hFFEC);
    chk("R9 ret held", {16'd0, ret_addr}, 32'h07FF);
    swi_req = 1'b0;
    do_ack();
    clear_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status_map();
    t_each_group();
    t_priority();
    t_swi();
    t_mask();
    t_hold();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule